// File: doc/BRIEF.md
# Run-Length Phase Predictor

This block forecasts the phase ID of the next execution interval. A classifier elsewhere in the chip labels every fixed-length interval with a phase ID. The block takes that ID together with a one-cycle valid strobe, once per interval. It keeps a short history made of `LEVELS` (phase ID, burst length) pairs. The newest pair is the burst still in progress, with the number of intervals it has run so far.

Each time an interval is observed, the history is folded into a `HASH_W`-bit key. The low `IDX_W` bits select a table entry, and the remaining high bits are compared against the tag stored in that entry. Each entry holds a valid bit, a tag, a next phase ID and a saturating counter. A matching entry whose counter is above `THRESH` predicts a jump to its stored ID in the very next interval. In every other case the block predicts that the current phase continues.

The one counter per entry serves two purposes:
- It is the confidence that gates the change prediction.
- It is the guard for conditional update: the contents of an entry are only replaced or removed once its counter has drained to zero.

Downstream logic reads `pred_phase` to prepare for a coming phase change before it happens.

Top module: `rlep_predictor`

## Requirements
- R1: While `rst` is high, and after it until the first valid observation, `pred_phase` is 0. Reset empties the table and the history, so learned patterns from before the reset have no effect afterwards.
- R2: After the first valid observation following reset, `pred_phase` equals that observed phase ID.
- R3: When the current history key selects an entry that is invalid or whose tag differs, `pred_phase` equals the current phase, which is the last observed ID.
- R4: On a tag match, `pred_phase` is the stored next ID only if the entry's counter is strictly greater than `THRESH`; otherwise it is the current phase.
- R5: On each valid observation that hits, the entry's `CNT_W`-bit counter steps up by one (saturating at all ones) when the stored ID equals the observed ID, and steps down by one (stopping at 0) when it differs.
- R6: A valid observation whose ID differs from the current phase, when the key has no tag match, writes a new entry if the slot is invalid or its counter is 0. The new entry has the new tag, the observed ID as next ID, and counter 0. If the slot's counter is nonzero, that counter is decremented instead.
- R7: On a hit whose stored ID is wrong, with counter 0 and an actual phase change, the stored next ID is rewritten to the observed ID.
- R8: On a hit whose stored ID differs from the observed ID, with counter 0 and no phase change, the entry is invalidated.
- R9: On a hit whose stored ID is wrong while the counter is nonzero, only the counter changes; the stored ID and valid bit are kept.
- R10: The key is the XOR of the `LEVELS` pairs {phase, length}, newest first. Pair i is shifted left by floor(i·(HASH_W−PAIR_W)/(LEVELS−1)) bits. The newest pair carries the running length, which restarts at 1 on a phase change and saturates at 2^LEN_W−1.
- R11: While `obs_valid` is low, `obs_phase` is ignored and `pred_phase` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| obs_valid | input | 1 | One-cycle strobe: `obs_phase` holds the phase ID of a finished interval |
| obs_phase | input | PHASE_W | Observed phase ID of that interval |
| pred_phase | output | PHASE_W | Predicted phase ID of the next interval, valid from the cycle after the strobe |

## Verification
The assertions check on every cycle the properties that hold at a single point in time:
- the reset value and the first-interval prediction;
- that a miss predicts the last observed ID, and that a change prediction appears only behind a confident hit;
- the restart and saturation of the running length;
- that idle cycles leave the prediction unchanged.

Properties that need whole sequences can only be shown by the bench's scenarios. These are the counter trajectories that delay the first change prediction, the survival of an entry through one noisy interval, the rewrite of a stored ID, and the deletion of a wrong entry. The deletion is visible only as one extra round of learning before the change is predicted again.

// File: rtl/rlep_pkg.sv
package rlep_pkg;

    // Action applied to the table slot selected by the current key.
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_INSERT,
        ACT_REWRITE,
        ACT_DELETE,
        ACT_STRENGTHEN,
        ACT_WEAKEN
    } tbl_act_e;

    // Left shift applied to history pair `lvl` before the XOR fold.
    function automatic int fold_shift(int lvl, int levels, int hash_w, int pair_w);
        if (levels < 2) begin
            return 0;
        end
        return (lvl * (hash_w - pair_w)) / (levels - 1);
    endfunction

endpackage

// File: rtl/rlep_history.sv
module rlep_history
    import rlep_pkg::*;
#(
    parameter int PHASE_W = 4,
    parameter int LEN_W   = 3,
    parameter int LEVELS  = 2,
    parameter int HASH_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               obs_valid,
    input  logic [PHASE_W-1:0] obs_phase,
    output logic               started,
    output logic [PHASE_W-1:0] cur_phase,
    output logic [LEN_W-1:0]   cur_len,
    output logic [HASH_W-1:0]  key
);
    localparam int PAIR_W = PHASE_W + LEN_W;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    // Slot 0 is the burst in progress; higher slots are older bursts.
    logic [PAIR_W-1:0] pair_q [LEVELS];
    logic              started_q;
    logic              new_burst;

    assign started   = started_q;
    assign cur_phase = pair_q[0][PAIR_W-1:LEN_W];
    assign cur_len   = pair_q[0][LEN_W-1:0];
    assign new_burst = !started_q || (obs_phase != cur_phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            for (int i = 0; i < LEVELS; i++) begin
                pair_q[i] <= '0;
            end
        end else if (obs_valid) begin
            started_q <= 1'b1;
            if (new_burst) begin
                for (int i = LEVELS - 1; i > 0; i--) begin
                    pair_q[i] <= pair_q[i-1];
                end
                pair_q[0] <= {obs_phase, LEN_W'(1)};
            end else if (cur_len != LEN_MAX) begin
                pair_q[0][LEN_W-1:0] <= cur_len + LEN_W'(1);
            end
        end
    end

    // Shift-and-XOR fold of all pairs into the key.
    logic [HASH_W-1:0] acc [LEVELS+1];
    assign acc[0] = '0;

    for (genvar g = 0; g < LEVELS; g++) begin : g_fold
        localparam int SH = fold_shift(g, LEVELS, HASH_W, PAIR_W);
        assign acc[g+1] = acc[g] ^ (HASH_W'(pair_q[g]) << SH);
    end

    assign key = acc[LEVELS];

endmodule

// File: rtl/rlep_table.sv
module rlep_table
    import rlep_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 4,
    parameter int PHASE_W = 4,
    parameter int CNT_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [TAG_W-1:0]   rd_tag,
    input  tbl_act_e           act,
    input  logic [PHASE_W-1:0] wr_phase,
    output logic               lk_valid,
    output logic               lk_hit,
    output logic [PHASE_W-1:0] lk_next,
    output logic [CNT_W-1:0]   lk_cnt
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic               vld_q [DEPTH];
    logic [TAG_W-1:0]   tag_q [DEPTH];
    logic [PHASE_W-1:0] nxt_q [DEPTH];
    logic [CNT_W-1:0]   cnt_q [DEPTH];

    assign lk_valid = vld_q[rd_idx];
    assign lk_hit   = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign lk_next  = nxt_q[rd_idx];
    assign lk_cnt   = cnt_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                nxt_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else begin
            unique case (act)
                ACT_INSERT: begin
                    vld_q[rd_idx] <= 1'b1;
                    tag_q[rd_idx] <= rd_tag;
                    nxt_q[rd_idx] <= wr_phase;
                    cnt_q[rd_idx] <= '0;
                end
                ACT_REWRITE: begin
                    nxt_q[rd_idx] <= wr_phase;
                end
                ACT_DELETE: begin
                    vld_q[rd_idx] <= 1'b0;
                end
                ACT_STRENGTHEN: begin
                    if (cnt_q[rd_idx] != CNT_MAX) begin
                        cnt_q[rd_idx] <= cnt_q[rd_idx] + CNT_W'(1);
                    end
                end
                ACT_WEAKEN: begin
                    if (cnt_q[rd_idx] != '0) begin
                        cnt_q[rd_idx] <= cnt_q[rd_idx] - CNT_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/rlep_policy.sv
module rlep_policy
    import rlep_pkg::*;
#(
    parameter int PHASE_W = 4,
    parameter int CNT_W   = 2,
    parameter int THRESH  = 1
) (
    input  logic               obs_valid,
    input  logic               started,
    input  logic [PHASE_W-1:0] obs_phase,
    input  logic [PHASE_W-1:0] cur_phase,
    input  logic               lk_valid,
    input  logic               lk_hit,
    input  logic [PHASE_W-1:0] lk_next,
    input  logic [CNT_W-1:0]   lk_cnt,
    output tbl_act_e           act,
    output logic [PHASE_W-1:0] pred_phase
);
    localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

    logic confident;
    logic changed;
    logic matched;
    logic cnt_zero;

    always_comb begin
        confident  = lk_hit && (lk_cnt > THR);
        pred_phase = confident ? lk_next : cur_phase;
    end

    always_comb begin
        changed  = (obs_phase != cur_phase);
        matched  = (lk_next == obs_phase);
        cnt_zero = (lk_cnt == '0);
        act      = ACT_NONE;
        if (obs_valid && started) begin
            if (lk_hit) begin
                if (matched) begin
                    act = ACT_STRENGTHEN;
                end else if (!cnt_zero) begin
                    act = ACT_WEAKEN;
                end else if (changed) begin
                    act = ACT_REWRITE;
                end else begin
                    act = ACT_DELETE;
                end
            end else if (changed) begin
                if (!lk_valid || cnt_zero) begin
                    act = ACT_INSERT;
                end else begin
                    act = ACT_WEAKEN;
                end
            end
        end
    end

endmodule

// File: rtl/rlep_predictor.sv
module rlep_predictor
    import rlep_pkg::*;
#(
    parameter int PHASE_W = 4,
    parameter int LEN_W   = 3,
    parameter int LEVELS  = 2,
    parameter int HASH_W  = 8,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 2,
    parameter int THRESH  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               obs_valid,
    input  logic [PHASE_W-1:0] obs_phase,
    output logic [PHASE_W-1:0] pred_phase
);
    localparam int TAG_W = HASH_W - IDX_W;

    logic               started;
    logic [PHASE_W-1:0] cur_phase;
    logic [LEN_W-1:0]   cur_len;
    logic [HASH_W-1:0]  key;
    logic [IDX_W-1:0]   lk_idx;
    logic [TAG_W-1:0]   lk_tag;
    logic               lk_valid;
    logic               lk_hit;
    logic [PHASE_W-1:0] lk_next;
    logic [CNT_W-1:0]   lk_cnt;
    tbl_act_e           act;

    assign lk_idx = key[IDX_W-1:0];
    assign lk_tag = key[HASH_W-1:IDX_W];

    rlep_history #(
        .PHASE_W (PHASE_W),
        .LEN_W   (LEN_W),
        .LEVELS  (LEVELS),
        .HASH_W  (HASH_W)
    ) u_hist (
        .clk       (clk),
        .rst       (rst),
        .obs_valid (obs_valid),
        .obs_phase (obs_phase),
        .started   (started),
        .cur_phase (cur_phase),
        .cur_len   (cur_len),
        .key       (key)
    );

    rlep_table #(
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .PHASE_W (PHASE_W),
        .CNT_W   (CNT_W)
    ) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_tag   (lk_tag),
        .act      (act),
        .wr_phase (obs_phase),
        .lk_valid (lk_valid),
        .lk_hit   (lk_hit),
        .lk_next  (lk_next),
        .lk_cnt   (lk_cnt)
    );

    rlep_policy #(
        .PHASE_W (PHASE_W),
        .CNT_W   (CNT_W),
        .THRESH  (THRESH)
    ) u_pol (
        .obs_valid  (obs_valid),
        .started    (started),
        .obs_phase  (obs_phase),
        .cur_phase  (cur_phase),
        .lk_valid   (lk_valid),
        .lk_hit     (lk_hit),
        .lk_next    (lk_next),
        .lk_cnt     (lk_cnt),
        .act        (act),
        .pred_phase (pred_phase)
    );

endmodule

// File: rtl/rlep_checker.sv
module rlep_checker #(
    parameter int PHASE_W = 4,
    parameter int LEN_W   = 3,
    parameter int CNT_W   = 2,
    parameter int THRESH  = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               obs_valid,
    input logic [PHASE_W-1:0] obs_phase,
    input logic [PHASE_W-1:0] pred_phase,
    input logic [PHASE_W-1:0] cur_phase,
    input logic [LEN_W-1:0]   cur_len,
    input logic               started,
    input logic               lk_hit,
    input logic [CNT_W-1:0]   lk_cnt
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    localparam logic [CNT_W-1:0] THR     = CNT_W'(THRESH);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pred_phase == '0)); // R1

    AST_FIRST_SELF: assert property (@(posedge clk) disable iff (rst)
        (obs_valid && !started) |=> (pred_phase == $past(obs_phase))); // R2

    AST_MISS_LASTVAL: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (pred_phase == cur_phase)); // R3

    AST_CHANGE_NEEDS_CONF: assert property (@(posedge clk) disable iff (rst)
        (pred_phase != cur_phase) |-> (lk_hit && (lk_cnt > THR))); // R4

    AST_LEN_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (obs_valid && started && (obs_phase == cur_phase) && (cur_len == LEN_MAX))
        |=> (cur_len == LEN_MAX)); // R10

    AST_LEN_RESTART: assert property (@(posedge clk) disable iff (rst)
        (obs_valid && (!started || (obs_phase != cur_phase)))
        |=> (cur_len == LEN_W'(1))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !obs_valid |=> $stable(pred_phase)); // R11

endmodule

bind rlep_predictor rlep_checker #(
    .PHASE_W (PHASE_W),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W),
    .THRESH  (THRESH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .obs_valid  (obs_valid),
    .obs_phase  (obs_phase),
    .pred_phase (pred_phase),
    .cur_phase  (cur_phase),
    .cur_len    (cur_len),
    .started    (started),
    .lk_hit     (lk_hit),
    .lk_cnt     (lk_cnt)
);

// File: tb/sim_rlep_predictor.sv
`timescale 1ns/1ps
module sim_rlep_predictor;
    // Phase encodings used throughout: A = 1, B = 2, C = 3; 4'hF = no check.
    localparam logic [3:0] PA = 4'd1;
    localparam logic [3:0] PB = 4'd2;
    localparam logic [3:0] PC = 4'd3;
    localparam logic [3:0] NOCHK = 4'hF;

    // Scenario 1: {observed, expected prediction} per interval.
    localparam int N1 = 25;
    localparam logic [7:0] VEC1 [N1] = '{
        8'h11, 8'h11, 8'h22, 8'h22, 8'h11, 8'h11, 8'h22, 8'h22,
        8'h11, 8'h11, 8'h22, 8'h22, 8'h11, 8'h11, 8'h22, 8'h21,
        8'h11, 8'h12, 8'h22, 8'h21, 8'h22, 8'h11, 8'h11, 8'h22,
        8'h21
    };

    // Scenario 2 (after reset): pattern A A B B C with a rewrite.
    localparam int N2 = 23;
    localparam logic [7:0] VEC2 [N2] = '{
        8'h11, 8'h11, 8'h22, 8'h22, 8'h11, 8'h11, 8'h22, 8'h22,
        8'h33, 8'h11, 8'h1F, 8'h2F, 8'h22, 8'h3F, 8'h1F, 8'h1F,
        8'h2F, 8'h22, 8'h3F, 8'h1F, 8'h1F, 8'h2F, 8'h23
    };

    // Scenario 3 (after reset): deletion and a long saturating burst.
    localparam int N3 = 29;
    localparam logic [3:0] OBS3 [N3] = '{
        4'd1, 4'd1, 4'd2, 4'd2, 4'd1, 4'd1, 4'd2, 4'd2,
        4'd2, 4'd2, 4'd2, 4'd2, 4'd2, 4'd2, 4'd2, 4'd2, 4'd2,
        4'd1, 4'd1, 4'd2, 4'd2, 4'd1, 4'd1, 4'd2, 4'd2,
        4'd1, 4'd1, 4'd2, 4'd2
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       obs_valid = 1'b0;
    logic [3:0] obs_phase = 4'd0;
    logic [3:0] pred_phase;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rlep_predictor u0 (
        .clk        (clk),
        .rst        (rst),
        .obs_valid  (obs_valid),
        .obs_phase  (obs_phase),
        .pred_phase (pred_phase)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pred_phase actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [3:0] ph, input logic [3:0] exp, input string req);
        @(negedge clk);
        obs_valid = 1'b1;
        obs_phase = ph;
        @(negedge clk);
        obs_valid = 1'b0;
        if (exp != NOCHK) check(pred_phase, exp, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(pred_phase, 4'd0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check(pred_phase, 4'd0, "R1 after reset, before first strobe");
    endtask

    function automatic string tag1(int i);
        if (i == 7)  return "R4 hit below threshold";
        if (i == 15) return "R6 inserted entry predicts change";
        if (i == 17) return "R5 counter reached threshold";
        if (i >= 20) return "R9 entry survives one wrong interval";
        return "R3 last value on miss";
    endfunction

    function automatic string tag2(int i);
        if (i == 0)  return "R2 first interval";
        if (i == 3)  return "R1 table cleared by reset";
        if (i == 7)  return "R4 hit with counter 0";
        if (i == 12 || i == 17) return "R5 counter still at or below threshold";
        if (i == 22) return "R7 rewritten next ID";
        return "R3 last value";
    endfunction

    function automatic string tag3(int i);
        if (i == 8 || i == 28) return "R8 deleted entry relearned from zero";
        if (i >= 9 && i <= 16) return "R10 saturated burst length";
        return "R3 last value";
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check(pred_phase, 4'd0, "R1 reset value");
        rst = 1'b0;
        @(negedge clk);
        check(pred_phase, 4'd0, "R1 before first strobe");

        for (int i = 0; i < N1; i++) begin
            step(VEC1[i][7:4], VEC1[i][3:0], tag1(i));
        end

        // R11: strobe low with a different phase on the input.
        @(negedge clk);
        obs_phase = PC;
        repeat (3) @(negedge clk);
        check(pred_phase, PA, "R11 idle cycles ignored");

        do_reset();
        for (int i = 0; i < N2; i++) begin
            step(VEC2[i][7:4], VEC2[i][3:0], tag2(i));
        end

        do_reset();
        for (int i = 0; i < N3; i++) begin
            step(OBS3[i], OBS3[i], tag3(i));
        end
        check(pred_phase, PB, "R8 final prediction");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule